// File: doc/BRIEF.md
# Sync-Loaded Hold-Off Trigger Counter

This per-channel block delays a power-ramp start by a programmed number of master clock cycles. A sync event loads a 16-bit hold-off value into a down-counter. The counter then steps down once per clock. When it reaches one, the block issues a single-cycle ramp-start pulse and a scale-update pulse together. The counter then rests at zero until the next sync event.

A sync event is the OR of three sources:
- one of four sync pins, chosen by a 2-bit select;
- a sync bit carried in the serial data, which counts only while its enable is set;
- a software sync strobe.

A hold-off value of zero turns the counter off, so no trigger follows that sync. The ramp generator and the scale register downstream take the two pulses. A busy flag shows that a countdown is pending.

Top module: `hoc_trigger`

## Requirements
- R1: On any clock edge at which a sync event is present, the counter loads the current 16-bit `holdoff_i` value. After that edge, `busy_o` is 1 exactly when the loaded value is non-zero.
- R2: With no sync event, a non-zero count decreases by exactly one on every clock edge.
- R3: A sync event sampled at edge E with value N ≥ 1 raises `ramp_start_o` and `scale_upd_o` together during the cycle that follows edge E+N−1. The value N=1 therefore fires in the cycle right after the load edge.
- R4: The trigger lasts one cycle. After it the count rests at zero, `busy_o` goes to 0, and no further trigger occurs without a new sync event.
- R5: Loading the value 0 produces no trigger and leaves `busy_o` at 0. This includes a load of 0 during a running count, which cancels that count.
- R6: The pin sync used is `pin_sync_i[pin_sel_i]`, where the select value is the pin index (0 to 3). Activity on an unselected pin loads nothing.
- R7: `ser_sync_i` produces a sync event only while `ser_en_i` is 1. With the enable at 0 it loads nothing.
- R8: A `soft_sync_i` pulse loads the counter in the same way as a pin sync.
- R9: A sync event during a running count reloads the count from `holdoff_i`. The earlier countdown then produces no trigger.
- R10: Changes to `holdoff_i` after the load edge do not alter the count in progress.
- R11: While `rst_n` is 0, the count is 0 and both trigger outputs and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| holdoff_i | input | 16 | Programmed hold-off value, loaded on a sync event |
| ser_en_i | input | 1 | Lets the serial-data sync bit through |
| pin_sel_i | input | 2 | Index of the sync pin in use |
| pin_sync_i | input | 4 | Hardware sync pins |
| ser_sync_i | input | 1 | Sync bit taken from serial input data |
| soft_sync_i | input | 1 | Software sync strobe |
| ramp_start_o | output | 1 | One-cycle pulse that starts the power ramp |
| scale_upd_o | output | 1 | One-cycle pulse that updates the scale factor |
| busy_o | output | 1 | Countdown pending |

## Verification
A count that steps wrongly or loads the wrong value shows at the ports as a trigger that comes early, comes late, or never comes. The error is visible once the expected firing cycle has passed, that is, within N cycles of the load. A failure to park at zero would show as repeated triggers within one cycle, or as `busy_o` staying high after the pulse. A wrongly gated or wrongly selected sync source shows as `busy_o` rising one edge after stimulus that should have been ignored. The scoreboard therefore checks the exact firing cycle of every trigger, and checks `busy_o` directly after each sync stimulus.

// File: rtl/hoc_pkg.sv
package hoc_pkg;
  localparam int HOC_CNT_W = 16;
  localparam int HOC_PINS  = 4;
endpackage

// File: rtl/hoc_sync_merge.sv
module hoc_sync_merge #(
  parameter int NUM_PINS = hoc_pkg::HOC_PINS,
  localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] pin_sync_i,
  input  logic [SEL_W-1:0]    pin_sel_i,
  input  logic                ser_en_i,
  input  logic                ser_sync_i,
  input  logic                soft_sync_i,
  output logic                pin_evt_o,
  output logic                ser_evt_o,
  output logic                sync_evt_o
);
  logic [NUM_PINS-1:0] sel_hit;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign sel_hit[g] = pin_sync_i[g] && (pin_sel_i == SEL_W'(g));
  end

  assign pin_evt_o  = |sel_hit;
  assign ser_evt_o  = ser_en_i & ser_sync_i;
  assign sync_evt_o = pin_evt_o | ser_evt_o | soft_sync_i;
endmodule

// File: rtl/hoc_down_counter.sv
module hoc_down_counter #(
  parameter int CNT_W = hoc_pkg::HOC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic ld, input logic [CNT_W-1:0] val);
    if (ld)             return val;
    else if (cur != '0) return cur - ONE;
    else                return cur;
  endfunction

  function automatic logic at_fire(input logic [CNT_W-1:0] cur);
    return cur == ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= next_count(count_o, load_i, load_val_i);
  end

  assign fire_o = at_fire(count_o);
  assign busy_o = (count_o != '0);
endmodule

// File: rtl/hoc_trigger.sv
module hoc_trigger #(
  parameter int CNT_W    = hoc_pkg::HOC_CNT_W,
  parameter int NUM_PINS = hoc_pkg::HOC_PINS,
  localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    holdoff_i,
  input  logic                ser_en_i,
  input  logic [SEL_W-1:0]    pin_sel_i,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  input  logic                ser_sync_i,
  input  logic                soft_sync_i,
  output logic                ramp_start_o,
  output logic                scale_upd_o,
  output logic                busy_o
);
  logic             pin_evt;
  logic             ser_evt;
  logic             sync_evt;
  logic [CNT_W-1:0] count;
  logic             fire;

  hoc_sync_merge #(.NUM_PINS(NUM_PINS)) u_merge (
    .pin_sync_i (pin_sync_i),
    .pin_sel_i  (pin_sel_i),
    .ser_en_i   (ser_en_i),
    .ser_sync_i (ser_sync_i),
    .soft_sync_i(soft_sync_i),
    .pin_evt_o  (pin_evt),
    .ser_evt_o  (ser_evt),
    .sync_evt_o (sync_evt)
  );

  hoc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (sync_evt),
    .load_val_i(holdoff_i),
    .count_o   (count),
    .fire_o    (fire),
    .busy_o    (busy_o)
  );

  assign ramp_start_o = fire;
  assign scale_upd_o  = fire;
endmodule

// File: rtl/hoc_trigger_chk.sv
module hoc_trigger_chk #(
  parameter int CNT_W    = 16,
  parameter int NUM_PINS = 4,
  parameter int SEL_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_evt,
  input logic                pin_evt,
  input logic                ser_evt,
  input logic [CNT_W-1:0]    count,
  input logic [CNT_W-1:0]    holdoff_i,
  input logic                ser_en_i,
  input logic                soft_sync_i,
  input logic                ramp_start_o,
  input logic                scale_upd_o,
  input logic                busy_o
);
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> count == $past(holdoff_i));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_evt && count > CNT_W'(1)) |=> count == CNT_W'($past(count) - CNT_W'(1)));

  p_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_evt && count == CNT_W'(2)) |=> (ramp_start_o && scale_upd_o));

  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_start_o && !sync_evt) |=> (!ramp_start_o && !busy_o));

  p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_evt && count == '0) |=> (count == '0 && !ramp_start_o));

  p_ser_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en_i && !soft_sync_i && !pin_evt) |-> !sync_evt);

  p_ser_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_evt |-> ser_en_i);

  p_reset_r11: assert property (@(posedge clk)
    !rst_n |-> (count == '0 && !busy_o && !ramp_start_o && !scale_upd_o));
endmodule

bind hoc_trigger hoc_trigger_chk #(.CNT_W(CNT_W), .NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_evt    (sync_evt),
  .pin_evt     (pin_evt),
  .ser_evt     (ser_evt),
  .count       (count),
  .holdoff_i   (holdoff_i),
  .ser_en_i    (ser_en_i),
  .soft_sync_i (soft_sync_i),
  .ramp_start_o(ramp_start_o),
  .scale_upd_o (scale_upd_o),
  .busy_o      (busy_o)
);

// File: tb/sim_hoc_trigger.sv
module sim_hoc_trigger;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] holdoff_i = '0;
  logic        ser_en_i = 1'b0;
  logic [1:0]  pin_sel_i = '0;
  logic [3:0]  pin_sync_i = '0;
  logic        ser_sync_i = 1'b0;
  logic        soft_sync_i = 1'b0;
  logic        ramp_start_o, scale_upd_o, busy_o;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  hoc_trigger u0 (
    .clk(clk), .rst_n(rst_n), .holdoff_i(holdoff_i), .ser_en_i(ser_en_i),
    .pin_sel_i(pin_sel_i), .pin_sync_i(pin_sync_i), .ser_sync_i(ser_sync_i),
    .soft_sync_i(soft_sync_i), .ramp_start_o(ramp_start_o),
    .scale_upd_o(scale_upd_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected trigger cycles and compares them with the ports
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        chk(1'b0, "R3 missed trigger", 0, exp_q[0]);
        void'(exp_q.pop_front());
      end
      chk(ramp_start_o == scale_upd_o, "R3 strobes differ", int'(scale_upd_o), int'(ramp_start_o));
      if (ramp_start_o) begin
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          chk(1'b1, "R3", cyc, cyc);
          void'(exp_q.pop_front());
        end else begin
          chk(1'b0, "R3 R4 unexpected trigger", cyc,
              (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: kind 0 = pin, 1 = serial, 2 = software. Called at a negedge.
  task automatic drive_sync(input int kind, input int pin, input logic [15:0] val,
                            input string tag);
    int e;
    int keep[$];
    holdoff_i = val;
    case (kind)
      0: begin pin_sel_i = 2'(pin); pin_sync_i[pin] = 1'b1; end
      1: begin ser_en_i = 1'b1; ser_sync_i = 1'b1; end
      default: soft_sync_i = 1'b1;
    endcase
    e = cyc + 1;
    foreach (exp_q[i]) if (exp_q[i] < e) keep.push_back(exp_q[i]);
    exp_q = keep;
    if (val != 0) exp_q.push_back(e + int'(val) - 1);
    @(negedge clk);
    pin_sync_i = '0; ser_sync_i = 1'b0; soft_sync_i = 1'b0; ser_en_i = 1'b0;
    chk(busy_o == (val != 0), tag, int'(busy_o), int'(val != 0));
  endtask

  task automatic drain(input int limit);
    int n = 0;
    while (exp_q.size() > 0 && n < limit) begin @(negedge clk); n++; end
    wait_cyc(2);
    chk(!busy_o, "R4 busy after fire", int'(busy_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    // R11 reset state, with a sync present during reset
    soft_sync_i = 1'b1; holdoff_i = 16'd9;
    wait_cyc(1);
    chk(!busy_o && !ramp_start_o && !scale_upd_o, "R11", int'(busy_o), 0);
    soft_sync_i = 1'b0;
    rst_n = 1'b1;
    mon_en = 1'b1;
    wait_cyc(2);
    chk(!busy_o, "R11 idle after reset", int'(busy_o), 0);

    // R1 R2 R3 R6: pin 0 and pin 3
    drive_sync(0, 0, 16'd5, "R1 pin0 load");
    drain(20);
    drive_sync(0, 3, 16'd2, "R6 pin3 load");
    drain(20);

    // R7 serial enabled
    drive_sync(1, 0, 16'd7, "R7 serial load");
    drain(20);

    // R7 serial disabled: no load
    holdoff_i = 16'd6; ser_en_i = 1'b0; ser_sync_i = 1'b1;
    @(negedge clk); ser_sync_i = 1'b0;
    chk(!busy_o, "R7 disabled serial ignored", int'(busy_o), 0);
    wait_cyc(8);

    // R6 unselected pin ignored
    holdoff_i = 16'd6; pin_sel_i = 2'd1; pin_sync_i = 4'b0100;
    @(negedge clk); pin_sync_i = '0;
    chk(!busy_o, "R6 unselected pin ignored", int'(busy_o), 0);
    wait_cyc(8);

    // R8 soft sync
    drive_sync(2, 0, 16'd4, "R8 soft load");
    drain(20);

    // R5 zero value, and zero cancelling a running count
    drive_sync(2, 0, 16'd0, "R5 zero load");
    wait_cyc(5);
    chk(!busy_o, "R5 stays idle", int'(busy_o), 0);
    drive_sync(0, 1, 16'd20, "R1 load 20");
    wait_cyc(5);
    drive_sync(2, 0, 16'd0, "R5 cancel by zero");
    wait_cyc(25);

    // R9 reload mid-count
    drive_sync(0, 2, 16'd10, "R1 load 10");
    wait_cyc(4);
    drive_sync(2, 0, 16'd10, "R9 reload");
    drain(30);

    // R10 holdoff change after load
    drive_sync(0, 0, 16'd8, "R1 load 8");
    holdoff_i = 16'd3;
    wait_cyc(3);
    chk(busy_o, "R10 still counting", int'(busy_o), 1);
    drain(20);

    // R3 boundary value 1, R2 full 16-bit value
    drive_sync(2, 0, 16'd1, "R3 value one");
    drain(5);
    drive_sync(1, 0, 16'hFFFF, "R2 max value");
    wait_cyc(65000);
    chk(busy_o, "R2 still counting near end", int'(busy_o), 1);
    drain(1000);

    chk(exp_q.size() == 0, "R4 all triggers seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule